// File: doc/BRIEF.md
# Half-Duplex Transmit/Receive Mode Controller

This block decides whether a half-duplex line modem transmits or receives. A single request input selects the direction: a low level asks for transmit, a high level asks for receive. The request is brought into the reference clock domain through a two-stage synchroniser, and the block then drives mutually exclusive transmit-enable and receive-enable outputs for the analog and modem datapaths.

A transmit watchdog bounds how long the modem may hold the line. Once a transmit burst has lasted the full timeout (about 3 s of the 11.0592 MHz reference, or about 1.48 ms when the fast-test input is high), the block drops back to receive even though the request is still low. It then stays in receive until the request has been high for a minimum number of consecutive cycles, so a stuck or glitching request cannot grab the line again. A bypass-test input disables the watchdog and, while receiving, routes an external test bit into the clock-recovery path in place of the demodulated data.

An enable input acts as a synchronous active-low reset: while it is low the block is powered down, clears all state and keeps both enables off.

Top module: `hdx_mode_ctrl`

## Requirements
- R1: With the synchronised request at 0 the block is in transmit (`tx_en`=1, `rx_en`=0); with it at 1 it is in receive (`tx_en`=0, `rx_en`=1); `tx_en` and `rx_en` are never both 1.
- R2: The request passes a two-flop synchroniser, so a request change set up before a rising edge shows on `tx_en`/`rx_en` after the third rising edge, counting that one.
- R3: With `tst_fast`=0 and `tst_bypass`=0, an unbroken transmit run lasts exactly `LONG_TIMEOUT` cycles of `tx_en`=1 (default 33,177,600, about 3 s), then the block enters receive.
- R4: With `tst_fast`=1 and `tst_bypass`=0, the run lasts exactly `SHORT_TIMEOUT` cycles (default 16,384, about 1.48 ms).
- R5: After an automatic fallback, `tx_en` stays 0 and `rx_en` 1 for as long as the request stays 0.
- R6: After a fallback, a high pulse on the request shorter than `REARM_MIN` cycles (default 23, about 2 µs) is ignored; a pulse of at least `REARM_MIN` cycles re-arms, so the next low level starts transmit.
- R7: When the request returns to 1 before the timeout, the block goes to receive and a following 0 re-enters transmit with no minimum high time.
- R8: With `tst_bypass`=1 the watchdog is off: a request held at 0 keeps `tx_en`=1 beyond `LONG_TIMEOUT` cycles.
- R9: With `tst_bypass`=1 and the block in receive, `cr_test`=1 and `dem_out` equals `tst_data`; otherwise `cr_test`=0 and `dem_out` equals `dem_in`.
- R10: A rising edge with `pwr_en`=0 sets `pdown`=1, `tx_en`=0, `rx_en`=0 and clears all state, including a pending fallback lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| pwr_en | input | 1 | Active-low synchronous reset and power-down request (0 = powered down) |
| mode_req | input | 1 | Direction request, 0 = transmit, 1 = receive (asynchronous) |
| tst_fast | input | 1 | Selects the short watchdog timeout |
| tst_bypass | input | 1 | Disables the watchdog; in receive selects the test data path |
| tst_data | input | 1 | External test bit for the clock-recovery path |
| dem_in | input | 1 | Demodulated data from the demodulator |
| tx_en | output | 1 | Transmit path enable |
| rx_en | output | 1 | Receive path enable |
| pdown | output | 1 | Power-down indication |
| cr_test | output | 1 | Clock recovery fed from the test bit |
| dem_out | output | 1 | Data routed to clock recovery |

## Verification
The request is driven in random low/high segments shorter than the timeout, which checks the plain direction mapping and the synchroniser latency without the watchdog taking part. Held-low requests with each test setting separate the long timeout, the short timeout and the disabled watchdog by the measured length of the transmit run. Re-arm pulses of one cycle below and exactly at the minimum tell apart a correct width filter from one that is off by one, and a voluntary release shows that the minimum applies only after a fallback. Random data on both data inputs under each bypass setting shows which source reaches the clock-recovery path.

// File: rtl/hdx_pkg.sv
package hdx_pkg;

    typedef enum logic [1:0] {
        MODE_RX   = 2'd0,
        MODE_TX   = 2'd1,
        MODE_HOLD = 2'd2
    } mode_e;

    typedef struct packed {
        logic tx_en;
        logic rx_en;
        logic pdown;
        logic cr_test;
    } ctl_out_t;

    // Last count value of a transmit run for the selected timeout.
    function automatic int unsigned last_count(input logic fast,
                                               input int unsigned long_len,
                                               input int unsigned short_len);
        return fast ? (short_len - 1) : (long_len - 1);
    endfunction

endpackage

// File: rtl/hdx_sync.sv
module hdx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hdx_tx_timer.sv
module hdx_tx_timer import hdx_pkg::*; #(
    parameter int unsigned LONG_TIMEOUT  = 33177600,
    parameter int unsigned SHORT_TIMEOUT = 16384
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic fast,
    input  logic no_limit,
    output logic expire
);
    localparam int unsigned W = $clog2(LONG_TIMEOUT + 1);
    localparam logic [W-1:0] CNT_TOP = W'(LONG_TIMEOUT - 1);

    logic [W-1:0] cnt;
    logic [W-1:0] lim;

    assign lim = W'(last_count(fast, LONG_TIMEOUT, SHORT_TIMEOUT));

    always_ff @(posedge clk) begin
        if (rst || !run)        cnt <= '0;
        else if (cnt != CNT_TOP) cnt <= cnt + 1'b1;
    end

    assign expire = run && !no_limit && (cnt >= lim);
endmodule

// File: rtl/hdx_rearm.sv
module hdx_rearm #(
    parameter int unsigned REARM_MIN = 23
) (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic ok
);
    localparam int unsigned W = $clog2(REARM_MIN + 1);
    localparam logic [W-1:0] TOP = W'(REARM_MIN);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !level)   cnt <= '0;
        else if (cnt != TOP) cnt <= cnt + 1'b1;
    end

    assign ok = (cnt == TOP);
endmodule

// File: rtl/hdx_mode_fsm.sv
module hdx_mode_fsm import hdx_pkg::*; (
    input  logic  clk,
    input  logic  rst,
    input  logic  req_tx,
    input  logic  expire,
    input  logic  rearm_ok,
    output mode_e state
);
    mode_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            MODE_RX:   if (req_tx) nxt = MODE_TX;
            MODE_TX: begin
                if (!req_tx)     nxt = MODE_RX;
                else if (expire) nxt = MODE_HOLD;
            end
            MODE_HOLD: if (rearm_ok) nxt = MODE_RX;
            default:   nxt = MODE_RX;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= MODE_RX;
        else     state <= nxt;
    end
endmodule

// File: rtl/hdx_mode_ctrl.sv
module hdx_mode_ctrl import hdx_pkg::*; #(
    parameter int unsigned LONG_TIMEOUT  = 33177600,
    parameter int unsigned SHORT_TIMEOUT = 16384,
    parameter int unsigned REARM_MIN     = 23,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic pwr_en,
    input  logic mode_req,
    input  logic tst_fast,
    input  logic tst_bypass,
    input  logic tst_data,
    input  logic dem_in,
    output logic tx_en,
    output logic rx_en,
    output logic pdown,
    output logic cr_test,
    output logic dem_out
);
    logic     rst;
    logic     mode_s;
    logic     expire;
    logic     rearm_ok;
    logic     pdown_q;
    mode_e    st;
    ctl_out_t ctl;

    assign rst = !pwr_en;

    always_ff @(posedge clk) begin
        pdown_q <= !pwr_en;
    end

    hdx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (mode_req),
        .q   (mode_s)
    );

    hdx_tx_timer #(.LONG_TIMEOUT(LONG_TIMEOUT), .SHORT_TIMEOUT(SHORT_TIMEOUT)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (st == MODE_TX),
        .fast     (tst_fast),
        .no_limit (tst_bypass),
        .expire   (expire)
    );

    hdx_rearm #(.REARM_MIN(REARM_MIN)) u_rearm (
        .clk   (clk),
        .rst   (rst),
        .level (mode_s),
        .ok    (rearm_ok)
    );

    hdx_mode_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req_tx   (!mode_s),
        .expire   (expire),
        .rearm_ok (rearm_ok),
        .state    (st)
    );

    always_comb begin
        ctl.pdown   = pdown_q;
        ctl.tx_en   = (st == MODE_TX);
        ctl.rx_en   = (st != MODE_TX) && !pdown_q;
        ctl.cr_test = tst_bypass && (st == MODE_RX) && !pdown_q;
    end

    assign tx_en   = ctl.tx_en;
    assign rx_en   = ctl.rx_en;
    assign pdown   = ctl.pdown;
    assign cr_test = ctl.cr_test;
    assign dem_out = ctl.cr_test ? tst_data : dem_in;
endmodule

// File: rtl/hdx_mode_chk.sv
module hdx_mode_chk import hdx_pkg::*; #(
    parameter int unsigned LONG_TIMEOUT = 33177600
) (
    input logic  clk,
    input logic  pwr_en,
    input logic  tst_bypass,
    input logic  tx_en,
    input logic  rx_en,
    input logic  pdown,
    input mode_e state,
    input logic  rearm_ok,
    input logic  mode_s
);
    logic [31:0] tx_run;

    always_ff @(posedge clk) begin
        if (!pwr_en || tst_bypass) tx_run <= '0;
        else if (tx_en)            tx_run <= tx_run + 1;
        else                       tx_run <= '0;
    end

    assert_enables_exclusive_R1: assert property (@(posedge clk)
        disable iff (!pwr_en || pdown) $onehot0({tx_en, rx_en}));

    assert_run_bounded_R3: assert property (@(posedge clk)
        disable iff (!pwr_en || pdown) tx_run <= LONG_TIMEOUT);

    assert_lockout_holds_R5: assert property (@(posedge clk)
        disable iff (!pwr_en || pdown) (state == MODE_HOLD && !rearm_ok) |=> !tx_en);

    assert_bypass_keeps_tx_R8: assert property (@(posedge clk)
        disable iff (!pwr_en || pdown) (tst_bypass && tx_en && !mode_s) |=> tx_en);

    assert_powerdown_R10: assert property (@(posedge clk)
        !pwr_en |=> (pdown && !tx_en && !rx_en));
endmodule

bind hdx_mode_ctrl hdx_mode_chk #(.LONG_TIMEOUT(LONG_TIMEOUT)) u_chk (
    .clk        (clk),
    .pwr_en     (pwr_en),
    .tst_bypass (tst_bypass),
    .tx_en      (tx_en),
    .rx_en      (rx_en),
    .pdown      (pdown),
    .state      (st),
    .rearm_ok   (rearm_ok),
    .mode_s     (mode_s)
);

// File: tb/tb_hdx_mode_ctrl.sv
`timescale 1ns/1ps
module tb_hdx_mode_ctrl;
    localparam int unsigned T_LONG  = 3000;
    localparam int unsigned T_SHORT = 200;
    localparam int unsigned T_MIN   = 23;

    logic clk = 1'b0;
    logic pwr_en, mode_req, tst_fast, tst_bypass, tst_data, dem_in;
    logic tx_en, rx_en, pdown, cr_test, dem_out;
    int   total = 0;
    int   bad = 0;

    always #2.5 clk = ~clk;

    hdx_mode_ctrl #(.LONG_TIMEOUT(T_LONG), .SHORT_TIMEOUT(T_SHORT), .REARM_MIN(T_MIN)) dut (
        .clk(clk), .pwr_en(pwr_en), .mode_req(mode_req), .tst_fast(tst_fast),
        .tst_bypass(tst_bypass), .tst_data(tst_data), .dem_in(dem_in),
        .tx_en(tx_en), .rx_en(rx_en), .pdown(pdown), .cr_test(cr_test), .dem_out(dem_out)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(input logic fast);
        return fast ? int'(T_SHORT) : int'(T_LONG);
    endfunction

    // Length of the next transmit run, sampled once per cycle.
    task automatic measure(output int len);
        int guard = 0;
        len = 0;
        while (!tx_en && guard < 20) begin tick(1); guard++; end
        while (tx_en && len < 20000) begin len++; tick(1); end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        int len;
        void'($urandom(32'h5EED_1234));
        pwr_en = 1'b0; mode_req = 1'b1; tst_fast = 1'b0;
        tst_bypass = 1'b0; tst_data = 1'b0; dem_in = 1'b0;
        tick(3);
        chk("R10 pdown in reset", pdown, 1);
        chk("R10 tx_en in reset", tx_en, 0);
        chk("R10 rx_en in reset", rx_en, 0);
        pwr_en = 1'b1;
        tick(2);
        chk("R1 idle rx_en", rx_en, 1);
        chk("R1 idle tx_en", tx_en, 0);
        chk("R10 pdown released", pdown, 0);

        // R2: latency through the synchroniser
        mode_req = 1'b0;
        tick(2);
        chk("R2 no change after two edges", tx_en, 0);
        tick(1);
        chk("R2 tx after third edge", tx_en, 1);

        // R7: voluntary release and immediate re-entry
        mode_req = 1'b1; tick(3);
        chk("R7 release to rx", rx_en, 1);
        mode_req = 1'b0; tick(3);
        chk("R7 re-entry without minimum", tx_en, 1);
        mode_req = 1'b1; tick(5);

        // R3 / R5: long timeout and lockout
        mode_req = 1'b0;
        measure(len);
        chk("R3 long run length", len, exp_len(1'b0));
        tick(50);
        chk("R5 lockout tx_en", tx_en, 0);
        chk("R5 lockout rx_en", rx_en, 1);

        // R6: re-arm pulse width
        mode_req = 1'b1; tick(T_MIN - 1); mode_req = 1'b0; tick(10);
        chk("R6 short pulse ignored", tx_en, 0);
        mode_req = 1'b1; tick(T_MIN); mode_req = 1'b0; tick(10);
        chk("R6 full pulse re-arms", tx_en, 1);
        mode_req = 1'b1; tick(30);

        // R4: short timeout
        tst_fast = 1'b1; mode_req = 1'b0;
        measure(len);
        chk("R4 short run length", len, exp_len(1'b1));
        tst_fast = 1'b0; mode_req = 1'b1; tick(30);

        // R8: watchdog disabled
        tst_bypass = 1'b1; mode_req = 1'b0;
        tick(T_LONG + 500);
        chk("R8 tx held past timeout", tx_en, 1);

        // R9: test data path
        mode_req = 1'b1; tick(5);
        chk("R9 cr_test in bypass rx", cr_test, 1);
        for (int i = 0; i < 8; i++) begin
            tst_data = 1'($urandom); dem_in = 1'($urandom); #1;
            chk("R9 dem_out follows tst_data", dem_out, tst_data);
            tick(1);
        end
        tst_bypass = 1'b0; tick(2);
        chk("R9 cr_test off", cr_test, 0);
        for (int i = 0; i < 8; i++) begin
            tst_data = 1'($urandom); dem_in = 1'($urandom); #1;
            chk("R9 dem_out follows dem_in", dem_out, dem_in);
            tick(1);
        end

        // R10: reset clears a pending lockout
        tst_fast = 1'b1; mode_req = 1'b0;
        measure(len);
        chk("R4 short run before reset", len, exp_len(1'b1));
        pwr_en = 1'b0; tick(1);
        chk("R10 pdown on reset", pdown, 1);
        chk("R10 tx_en off on reset", tx_en, 0);
        pwr_en = 1'b1; tick(5);
        chk("R10 lockout cleared", tx_en, 1);
        tst_fast = 1'b0; mode_req = 1'b1; tick(30);

        // R1: random request segments shorter than the timeout
        for (int s = 0; s < 25; s++) begin
            logic v;
            int   seg;
            v   = 1'($urandom);
            seg = 8 + int'($urandom % 50);
            mode_req = v;
            tick(seg);
            chk("R1 random tx_en", tx_en, (v == 1'b0) ? 1 : 0);
            chk("R1 random rx_en", rx_en, (v == 1'b1) ? 1 : 0);
        end

        summary();
    end
endmodule